// File: doc/BRIEF.md
# PWM Timing Register Shadow and Commit Unit

This block sits between a software register write port and a PWM waveform generator. It holds four compare values and an output-configuration byte. The compare values are a set edge and a reset edge for each of the two outputs, A and B. Software writes land in shadow copies. The generator only sees the active copies, which the outputs carry. A whole pending set is copied from shadow to active in one clock, so the generator never runs a cycle on a mix of old and new values.

When that copy happens is decided by a small control register with two bits, hold and auto-arm, together with an end-of-cycle pulse from the PWM counter and a stop/restart input. In free mode any shadowed write arms a commit. Hold blocks commits at cycle ends. In auto-arm mode only a write to the reset-B compare arms a commit, and auto-arm overrides hold. Two input-select bits in the configuration byte bypass the shadow and go live at once.

Top module: `pwm_shadow_sync`

## Requirements
- R1: While reset is asserted, all five active outputs read zero. The shadow copies and the control register are also cleared.
- R2: Write addresses are 0 set A, 1 reset A, 2 set B, 3 reset B, 4 configuration and 5 control. A write to addresses 0 to 4 changes only the shadow copy. The active outputs change only in the clock after an edge where cycle_end or restart is high. The one exception is the bypass bits of R9.
- R3: With hold and auto-arm both 0, any write to addresses 0 to 4 arms a commit. At the next cycle_end, all five shadow values become active together.
- R4: With control bit 0 (hold) set and auto-arm not in effect, no cycle_end commits anything, however many writes occur.
- R5: After hold is cleared, an armed set is committed at the next cycle_end.
- R6: With auto-arm in effect, only a write to address 3 arms a commit. Writes to addresses 0, 1, 2 and 4 update the shadows but do not arm.
- R7: With auto-arm in effect, an armed set is committed at cycle_end even if hold is set.
- R8: A write to control bit 1 (auto-arm) changes the arming mode only at the first cycle_end after the write. Until then the previous mode governs both arming and committing.
- R9: Configuration bits 7 and 6 are input selects. One clock after a write to address 4, they appear on the active configuration output without waiting for a commit.
- R10: A restart pulse commits an armed set in the same clock, whatever the hold and auto-arm settings.
- R11: A write on the same edge as cycle_end is not part of that commit. It is committed at a later one.
- R12: A commit clears the armed state. A later cycle_end with no new arming write leaves the outputs unchanged.
- R13: Writes to addresses 6 and 7 have no effect on any output or on the arming state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 12 | Register write data (configuration and control use the low bits) |
| cycle_end | input | 1 | End-of-PWM-cycle pulse from the counter |
| restart | input | 1 | Stop/restart request, commits immediately |
| act_set_a | output | 12 | Active set-edge compare, output A |
| act_rst_a | output | 12 | Active reset-edge compare, output A |
| act_set_b | output | 12 | Active set-edge compare, output B |
| act_rst_b | output | 12 | Active reset-edge compare, output B |
| act_cfg | output | 8 | Active output-configuration byte |

## Verification
Directed sequences try the commit path under each control setting. Free mode, held, hold released, auto-arm pending and auto-arm in effect each separate a commit that fires from one that must wait. Other directed cases put a write on the same edge as cycle_end, switch the auto-arm bit between two cycle ends, and send a restart while hold is set; these show the difference between arming state taken before the edge and state taken after it. A long run of seeded random writes, cycle ends and restarts, with control writes mixed in, is compared every clock against a reference model. That run shows whether an active value ever moves at a point that no requirement allows.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
   localparam int ADDR_W = 3;

   localparam logic [ADDR_W-1:0] ADR_SET_A = 3'd0;
   localparam logic [ADDR_W-1:0] ADR_RST_A = 3'd1;
   localparam logic [ADDR_W-1:0] ADR_SET_B = 3'd2;
   localparam logic [ADDR_W-1:0] ADR_RST_B = 3'd3;
   localparam logic [ADDR_W-1:0] ADR_CFG   = 3'd4;
   localparam logic [ADDR_W-1:0] ADR_CTRL  = 3'd5;

   localparam int N_CMP         = 4;
   localparam int CTRL_HOLD_BIT = 0;
   localparam int CTRL_AUTO_BIT = 1;

   typedef struct packed {
      logic auto_arm;
      logic hold;
   } ctrl_t;
endpackage

// File: rtl/pwm_shadow_bank.sv
module pwm_shadow_bank
   import pwm_shadow_pkg::*;
#(
   parameter int CMP_W  = 12,
   parameter int CFG_W  = 8,
   parameter int DATA_W = 12
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [DATA_W-1:0]           wr_data,
   output logic [N_CMP-1:0][CMP_W-1:0] sh_cmp,
   output logic [CFG_W-1:0]            sh_cfg,
   output ctrl_t                       ctrl
);
   genvar gi;
   generate
      for (gi = 0; gi < N_CMP; gi++) begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sh_cmp[gi] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(gi))
               sh_cmp[gi] <= wr_data[CMP_W-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         sh_cfg <= '0;
      else if (wr_en && wr_addr == ADR_CFG)
         sh_cfg <= wr_data[CFG_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl <= '0;
      end else if (wr_en && wr_addr == ADR_CTRL) begin
         ctrl.hold     <= wr_data[CTRL_HOLD_BIT];
         ctrl.auto_arm <= wr_data[CTRL_AUTO_BIT];
      end
   end
endmodule

// File: rtl/pwm_commit_ctrl.sv
module pwm_commit_ctrl
   import pwm_shadow_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              cycle_end,
   input  logic              restart,
   input  ctrl_t             ctrl,
   output logic              commit,
   output logic              pending,
   output logic              auto_eff
);
   logic shadowed_wr;
   logic arm;

   always_comb begin
      shadowed_wr = wr_en && (wr_addr <= ADR_CFG);
      arm         = auto_eff ? (wr_en && wr_addr == ADR_RST_B) : shadowed_wr;
      commit      = pending && (restart || (cycle_end && (auto_eff || !ctrl.hold)));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pending  <= 1'b0;
         auto_eff <= 1'b0;
      end else begin
         if (arm)
            pending <= 1'b1;
         else if (commit)
            pending <= 1'b0;
         if (cycle_end)
            auto_eff <= ctrl.auto_arm;
      end
   end
endmodule

// File: rtl/pwm_active_bank.sv
module pwm_active_bank
   import pwm_shadow_pkg::*;
#(
   parameter int               CMP_W       = 12,
   parameter int               CFG_W       = 8,
   parameter logic [CFG_W-1:0] BYPASS_MASK = 8'hC0
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        commit,
   input  logic [N_CMP-1:0][CMP_W-1:0] sh_cmp,
   input  logic [CFG_W-1:0]            sh_cfg,
   input  logic                        cfg_wr,
   input  logic [CFG_W-1:0]            cfg_wdata,
   output logic [N_CMP-1:0][CMP_W-1:0] act_cmp,
   output logic [CFG_W-1:0]            act_cfg
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act_cmp <= '0;
      else if (commit)
         act_cmp <= sh_cmp;
   end

   genvar gb;
   generate
      for (gb = 0; gb < CFG_W; gb++) begin : g_cfg
         if (BYPASS_MASK[gb]) begin : g_live
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  act_cfg[gb] <= 1'b0;
               else if (cfg_wr)
                  act_cfg[gb] <= cfg_wdata[gb];
               else if (commit)
                  act_cfg[gb] <= sh_cfg[gb];
            end
         end else begin : g_shadowed
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)
                  act_cfg[gb] <= 1'b0;
               else if (commit)
                  act_cfg[gb] <= sh_cfg[gb];
            end
         end
      end
   endgenerate
endmodule

// File: rtl/pwm_shadow_sync.sv
module pwm_shadow_sync
   import pwm_shadow_pkg::*;
#(
   parameter int               CMP_W       = 12,
   parameter int               CFG_W       = 8,
   parameter logic [CFG_W-1:0] BYPASS_MASK = 8'hC0,
   localparam int              DATA_W      = (CMP_W > CFG_W) ? CMP_W : CFG_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              cycle_end,
   input  logic              restart,
   output logic [CMP_W-1:0]  act_set_a,
   output logic [CMP_W-1:0]  act_rst_a,
   output logic [CMP_W-1:0]  act_set_b,
   output logic [CMP_W-1:0]  act_rst_b,
   output logic [CFG_W-1:0]  act_cfg
);
   generate
      if (CMP_W < 2 || CMP_W > 32) begin : g_bad_cmp
         $error("pwm_shadow_sync: CMP_W must lie in 2..32");
      end
      if (CFG_W < 2 || CFG_W > 32) begin : g_bad_cfg
         $error("pwm_shadow_sync: CFG_W must lie in 2..32");
      end
   endgenerate

   logic [N_CMP-1:0][CMP_W-1:0] sh_cmp;
   logic [N_CMP-1:0][CMP_W-1:0] act_cmp;
   logic [CFG_W-1:0]            sh_cfg;
   ctrl_t                       ctrl;
   logic                        commit;
   logic                        pending;
   logic                        auto_eff;
   logic                        cfg_wr;

   assign cfg_wr = wr_en && wr_addr == ADR_CFG;

   pwm_shadow_bank #(.CMP_W(CMP_W), .CFG_W(CFG_W), .DATA_W(DATA_W)) u_shadow (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .sh_cmp  (sh_cmp),
      .sh_cfg  (sh_cfg),
      .ctrl    (ctrl)
   );

   pwm_commit_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .cycle_end (cycle_end),
      .restart   (restart),
      .ctrl      (ctrl),
      .commit    (commit),
      .pending   (pending),
      .auto_eff  (auto_eff)
   );

   pwm_active_bank #(.CMP_W(CMP_W), .CFG_W(CFG_W), .BYPASS_MASK(BYPASS_MASK)) u_active (
      .clk       (clk),
      .rst_n     (rst_n),
      .commit    (commit),
      .sh_cmp    (sh_cmp),
      .sh_cfg    (sh_cfg),
      .cfg_wr    (cfg_wr),
      .cfg_wdata (wr_data[CFG_W-1:0]),
      .act_cmp   (act_cmp),
      .act_cfg   (act_cfg)
   );

   assign act_set_a = act_cmp[ADR_SET_A];
   assign act_rst_a = act_cmp[ADR_RST_A];
   assign act_set_b = act_cmp[ADR_SET_B];
   assign act_rst_b = act_cmp[ADR_RST_B];
endmodule

// File: rtl/pwm_shadow_sync_chk.sv
module pwm_shadow_sync_chk
   import pwm_shadow_pkg::*;
#(
   parameter int               CMP_W       = 12,
   parameter int               CFG_W       = 8,
   parameter logic [CFG_W-1:0] BYPASS_MASK = 8'hC0,
   parameter int               DATA_W      = 12
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        wr_en,
   input logic [2:0]                  wr_addr,
   input logic [DATA_W-1:0]           wr_data,
   input logic                        cycle_end,
   input logic                        restart,
   input logic [N_CMP-1:0][CMP_W-1:0] act_cmp,
   input logic [N_CMP-1:0][CMP_W-1:0] sh_cmp,
   input logic [CFG_W-1:0]            act_cfg,
   input logic                        hold,
   input logic                        auto_eff,
   input logic                        pending
);
   logic [N_CMP*CMP_W+CFG_W-1:0] act_bus;
   assign act_bus = {act_cmp, act_cfg & ~BYPASS_MASK};

   always @(negedge clk) begin
      if (!rst_n) begin
         a_r1_reset_zero: assert (act_bus == '0 && act_cfg == '0)
            else $error("R1: active outputs not zero in reset");
      end
   end

   a_r2_quiet_between: assert property (@(posedge clk) disable iff (!rst_n)
      (!cycle_end && !restart) |=> $stable(act_bus));

   a_r4_hold_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (hold && !auto_eff && !restart) |=> $stable(act_bus));

   a_r9_bypass_live: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADR_CFG) |=>
         ((act_cfg & BYPASS_MASK) == ($past(wr_data[CFG_W-1:0]) & BYPASS_MASK)));

   a_r10_restart_commit: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && pending) |=> (act_cmp == $past(sh_cmp)));

   a_r12_pending_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (restart && pending && !wr_en) |=> !pending);
endmodule

bind pwm_shadow_sync pwm_shadow_sync_chk #(
   .CMP_W(CMP_W), .CFG_W(CFG_W), .BYPASS_MASK(BYPASS_MASK), .DATA_W(DATA_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .cycle_end (cycle_end),
   .restart   (restart),
   .act_cmp   (act_cmp),
   .sh_cmp    (sh_cmp),
   .act_cfg   (act_cfg),
   .hold      (ctrl.hold),
   .auto_eff  (auto_eff),
   .pending   (pending)
);

// File: tb/sim_pwm_shadow_sync.sv
module sim_pwm_shadow_sync;
   localparam logic [7:0] MASK = 8'hC0;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [11:0] wr_data = '0;
   logic        cycle_end = 1'b0;
   logic        restart = 1'b0;
   logic [11:0] act_set_a, act_rst_a, act_set_b, act_rst_b;
   logic [7:0]  act_cfg;

   int checks = 0;
   int errors = 0;

   // reference model state
   logic [11:0] m_sh [4];
   logic [11:0] m_act [4];
   logic [7:0]  m_sh_cfg, m_act_cfg;
   logic        m_hold, m_auto, m_auto_eff, m_pend;

   always #5 clk = ~clk;

   pwm_shadow_sync u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .cycle_end(cycle_end), .restart(restart),
      .act_set_a(act_set_a), .act_rst_a(act_rst_a), .act_set_b(act_set_b),
      .act_rst_b(act_rst_b), .act_cfg(act_cfg)
   );

   function automatic logic [55:0] exp_bus();
      return {m_act[0], m_act[1], m_act[2], m_act[3], m_act_cfg};
   endfunction

   function automatic logic [55:0] dut_bus();
      return {act_set_a, act_rst_a, act_set_b, act_rst_b, act_cfg};
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 4; i++) begin
         m_sh[i] = '0;
         m_act[i] = '0;
      end
      m_sh_cfg = '0; m_act_cfg = '0;
      m_hold = 0; m_auto = 0; m_auto_eff = 0; m_pend = 0;
   endtask

   // applies one clock of stimulus to the model, using pre-edge state
   task automatic model_step(input logic we, input logic [2:0] a, input logic [11:0] d,
                             input logic ce, input logic rs);
      logic cm, armw;
      cm   = m_pend && (rs || (ce && (m_auto_eff || !m_hold)));
      armw = we && (m_auto_eff ? (a == 3'd3) : (a <= 3'd4));
      if (cm) begin
         for (int i = 0; i < 4; i++) m_act[i] = m_sh[i];
         m_act_cfg = m_sh_cfg;
      end
      if (we && a == 3'd4) m_act_cfg = (m_act_cfg & ~MASK) | (d[7:0] & MASK);
      if (ce) m_auto_eff = m_auto;
      if (we) begin
         if (a < 3'd4) m_sh[a[1:0]] = d;
         else if (a == 3'd4) m_sh_cfg = d[7:0];
         else if (a == 3'd5) begin
            m_hold = d[0];
            m_auto = d[1];
         end
      end
      if (armw) m_pend = 1'b1;
      else if (cm) m_pend = 1'b0;
   endtask

   task automatic check(input string req);
      checks++;
      if (dut_bus() !== exp_bus()) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, dut_bus(), exp_bus());
      end
   endtask

   // call at a negedge; drives, clocks, updates model, compares at next negedge
   task automatic step(input logic we, input logic [2:0] a, input logic [11:0] d,
                       input logic ce, input logic rs, input string req);
      wr_en = we; wr_addr = a; wr_data = d; cycle_end = ce; restart = rs;
      @(posedge clk);
      model_step(we, a, d, ce, rs);
      @(negedge clk);
      wr_en = 0; cycle_end = 0; restart = 0;
      check(req);
   endtask

   task automatic wr(input logic [2:0] a, input logic [11:0] d, input string req);
      step(1'b1, a, d, 1'b0, 1'b0, req);
   endtask

   task automatic tick_end(input string req);
      step(1'b0, 3'd0, 12'd0, 1'b1, 1'b0, req);
   endtask

   initial begin
      #2_000_000;
      errors++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      model_reset();
      void'($urandom(32'd4242));
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after release");

      // R13: unused addresses are ignored
      wr(3'd6, 12'hFFF, "R13 addr6");
      wr(3'd7, 12'hABC, "R13 addr7");
      tick_end("R13 nothing armed");

      // R3 free mode, R2 shadow only before commit
      wr(3'd0, 12'h123, "R2 shadow set A");
      wr(3'd1, 12'h456, "R2 shadow reset A");
      wr(3'd4, 12'h015, "R2 cfg shadow");
      tick_end("R3 free commit");
      tick_end("R12 no second commit");

      // R11 write coincident with cycle end
      step(1'b1, 3'd2, 12'h777, 1'b1, 1'b0, "R11 same-edge write not committed");
      tick_end("R11 committed next end");

      // R4 hold blocks commits
      wr(3'd5, 12'h001, "R4 set hold");
      wr(3'd3, 12'h9A9, "R4 write while held");
      tick_end("R4 held end 1");
      tick_end("R4 held end 2");
      wr(3'd0, 12'h321, "R4 write while held 2");
      tick_end("R4 held end 3");

      // R5 release hold
      wr(3'd5, 12'h000, "R5 release hold");
      tick_end("R5 commit after release");

      // R8 auto-arm switch delayed, R7 override of hold
      wr(3'd5, 12'h003, "R8 request auto with hold");
      wr(3'd0, 12'h0AA, "R8 free-mode arm still used");
      tick_end("R8 no commit at switching end");
      tick_end("R7 auto overrides hold");

      // R6 only reset-B arms
      wr(3'd0, 12'h0BB, "R6 set A write");
      wr(3'd4, 12'h002, "R6 cfg write");
      tick_end("R6 no arm from other regs");
      wr(3'd3, 12'h0CC, "R6 reset-B write");
      tick_end("R6 reset-B arms commit");

      // R9 bypass bits
      wr(3'd4, 12'h0C5, "R9 bypass bits live");
      wr(3'd4, 12'h040, "R9 bypass bits live again");

      // R10 restart while held in free mode
      wr(3'd5, 12'h001, "R10 hold, auto off requested");
      tick_end("R10 auto off takes effect");
      wr(3'd2, 12'h5A5, "R10 write while held");
      tick_end("R10 still held");
      step(1'b0, 3'd0, 12'd0, 1'b0, 1'b1, "R10 restart commits");
      tick_end("R12 cleared after restart");

      // random run against the model
      for (int n = 0; n < 4000; n++) begin
         logic we, ce, rs;
         logic [2:0] a;
         logic [11:0] d;
         we = ($urandom % 10) < 6;
         a  = 3'($urandom % 8);
         if (a == 3'd5 && ($urandom % 3) != 0) a = 3'd3;
         d  = 12'($urandom);
         ce = ($urandom % 4) == 0;
         rs = ($urandom % 32) == 0;
         step(we, a, d, ce, rs, "R2 random");
      end

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule